// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that moves a run of equally sized elements between one fixed device address and an advancing memory address. Software places a first descriptor (device address, memory address, a size word carrying the element count and width, and a link word) on the configuration inputs. It picks one-shot or chained operation and a direction, then pulses start. The channel checks the descriptor and issues one element request per element on a simple request/acknowledge transfer port. It raises a completion pulse at the end of every descriptor whose link word asks for one.

In chained mode the link word can point to another four-word descriptor in memory. The channel then reads those four words through a word-wide read port and runs the new descriptor. This repeats until a link word says end. A malformed descriptor stops the channel with an error pulse. The current activity is always visible as a two-bit state code. Arbitration between channels and the software register file lie outside this block.

Top module: `dma_chain_channel`

## Requirements
- R1: While reset is asserted and after it is released, the state code is 0 (idle), and no element request, descriptor read request, completion pulse or error pulse is raised.
- R2: A start pulse in idle captures the configuration inputs. The state code reads 2 (check) for exactly one cycle and then 3 (data access), with the captured device and memory addresses presented on the transfer port.
- R3: Size bits [13:12] give the element width: code 3 means 1 byte, code 2 means 2 bytes, code 0 means 4 bytes. The transfer port reports that byte count, and the memory address grows by it after every acknowledged element.
- R4: The element count is held in size bits [10:0]. A valid descriptor produces exactly that many acknowledged element requests, and the device address stays fixed for the whole descriptor.
- R5: When the last element of a valid descriptor is acknowledged, a one-cycle completion pulse follows if bit 0 of the link word is 1. No pulse follows if that bit is 0.
- R6: In one-shot mode the channel returns to idle after the loaded descriptor even if link bit 1 (follow) is set, and it makes no descriptor read.
- R7: In chained mode a link word with bit 1 set makes the channel read four words, at the link address with bits [1:0] cleared plus 0, 4, 8 and 12. These words are taken as device address, memory address, size and link, in that order, and the state code reads 1 while the reads are outstanding.
- R8: A descriptor with width code 1, a count of 0, or a count above 0x3FF with a 1- or 2-byte width (4-byte width allows up to 0x7FF) makes no element request. It raises the error and completion pulses in the same cycle and returns to idle.
- R9: A start pulse while the state code is not 0 is ignored, including a start on the cycle the final element is acknowledged.
- R10: The direction captured at start (1 = memory to device) is shown on the transfer port for every element of the run, including elements of fetched descriptors.
- R11: A malformed descriptor reached through a chain ends the chain as in R8. The elements of earlier descriptors have all completed by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| chain_mode_i | input | 1 | 1 = chained, 0 = one-shot |
| to_dev_i | input | 1 | Direction, 1 = memory to device |
| cfg_dev_addr_i | input | AW | First descriptor device address |
| cfg_mem_addr_i | input | AW | First descriptor memory address |
| cfg_size_i | input | AW | First descriptor size word |
| cfg_next_i | input | AW | First descriptor link word |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | AW | Descriptor word address |
| rd_valid_i | input | 1 | Read data valid, one word per cycle |
| rd_data_i | input | AW | Read data |
| xfer_req_o | output | 1 | Element transfer request |
| xfer_to_dev_o | output | 1 | Element direction |
| xfer_dev_addr_o | output | AW | Device address of the element |
| xfer_mem_addr_o | output | AW | Memory address of the element |
| xfer_bytes_o | output | 3 | Element size in bytes |
| xfer_ack_i | input | 1 | Element acknowledge |
| state_o | output | 2 | 0 idle, 1 descriptor read, 2 check, 3 data access |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error pulse |

## Verification
A start request and the acknowledge of a descriptor's final element can fall on the same clock edge. At that edge the channel is still in data access and is just about to turn idle. The bench drives start on exactly the cycle its own responder acknowledges the last element of a one-element run, with a changed memory address on the configuration inputs. It then judges that no further element request appears and the state code stays idle. The second collision is the error and completion pulses of a malformed descriptor. These must share one cycle, and the bench counts cycles where both are high.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CHECK = 2'd2,
    ST_MOVE  = 2'd3
  } chan_st_e;

  // width codes held in the size word
  localparam logic [1:0] WC_BYTE = 2'd3;
  localparam logic [1:0] WC_HALF = 2'd2;
  localparam logic [1:0] WC_WORD = 2'd0;
  localparam int         WC_LSB  = 12;

  // descriptor word order in memory
  localparam int DESC_WORDS = 4;
  localparam int DW_DEV     = 0;
  localparam int DW_MEM     = 1;
  localparam int DW_SIZE    = 2;
  localparam int DW_LINK    = 3;

  function automatic logic [2:0] wc_bytes(input logic [1:0] wc);
    case (wc)
      WC_BYTE: wc_bytes = 3'd1;
      WC_HALF: wc_bytes = 3'd2;
      WC_WORD: wc_bytes = 3'd4;
      default: wc_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmach_fetch.sv
module dmach_fetch
  import dmach_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go_i,
  input  logic [AW-1:0]                  base_i,
  output logic                           rd_req_o,
  output logic [AW-1:0]                  rd_addr_o,
  input  logic                           rd_valid_i,
  input  logic [AW-1:0]                  rd_data_i,
  output logic [DESC_WORDS-1:0][AW-1:0]  words_o,
  output logic                           done_o
);

  localparam int                IDX_W    = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DESC_WORDS - 1);

  logic                          busy_q, busy_d;
  logic [IDX_W-1:0]              idx_q, idx_d;
  logic [AW-1:0]                 base_q, base_d;
  logic [DESC_WORDS-1:0][AW-1:0] words_q, words_d;
  logic                          done_q, done_d;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    base_d  = base_q;
    words_d = words_q;
    done_d  = 1'b0;
    if (go_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      base_d = {base_i[AW-1:2], 2'b00};
    end else if (busy_q && rd_valid_i) begin
      words_d[idx_q] = rd_data_i;
      idx_d          = idx_q + 1'b1;
      if (idx_q == IDX_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
      words_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      if (go_i) base_q <= base_d;
      if (busy_q && rd_valid_i) words_q <= words_d;
    end
  end

  assign rd_req_o  = busy_q;
  assign rd_addr_o = base_q + AW'({idx_q, 2'b00});
  assign words_o   = words_q;
  assign done_o    = done_q;

  // R7
  fetch_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);

  // R7
  fetch_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/dmach_path.sv
module dmach_path
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_cfg_i,
  input  logic [AW-1:0]                 cfg_dev_i,
  input  logic [AW-1:0]                 cfg_mem_i,
  input  logic [AW-1:0]                 cfg_size_i,
  input  logic [AW-1:0]                 cfg_link_i,
  input  logic                          ld_fetch_i,
  input  logic [DESC_WORDS-1:0][AW-1:0] fetch_words_i,
  input  logic                          step_i,
  output logic [AW-1:0]                 dev_o,
  output logic [AW-1:0]                 mem_o,
  output logic [AW-1:0]                 link_o,
  output logic [2:0]                    bytes_o,
  output logic                          last_o,
  output logic                          bad_o
);

  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [AW-1:0]    dev_q, dev_d;
  logic [AW-1:0]    mem_q, mem_d;
  logic [AW-1:0]    link_q, link_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       wc_q, wc_d;
  logic             en;

  assign en = ld_cfg_i | ld_fetch_i | step_i;

  always_comb begin
    dev_d  = dev_q;
    mem_d  = mem_q;
    link_d = link_q;
    cnt_d  = cnt_q;
    wc_d   = wc_q;
    if (ld_cfg_i) begin
      dev_d  = cfg_dev_i;
      mem_d  = cfg_mem_i;
      link_d = cfg_link_i;
      cnt_d  = cfg_size_i[CNT_W-1:0];
      wc_d   = cfg_size_i[WC_LSB+1:WC_LSB];
    end else if (ld_fetch_i) begin
      dev_d  = fetch_words_i[DW_DEV];
      mem_d  = fetch_words_i[DW_MEM];
      link_d = fetch_words_i[DW_LINK];
      cnt_d  = fetch_words_i[DW_SIZE][CNT_W-1:0];
      wc_d   = fetch_words_i[DW_SIZE][WC_LSB+1:WC_LSB];
    end else if (step_i) begin
      mem_d = mem_q + AW'(wc_bytes(wc_q));
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      mem_q  <= '0;
      link_q <= '0;
      cnt_q  <= '0;
      wc_q   <= WC_WORD;
    end else if (en) begin
      dev_q  <= dev_d;
      mem_q  <= mem_d;
      link_q <= link_d;
      cnt_q  <= cnt_d;
      wc_q   <= wc_d;
    end
  end

  assign dev_o   = dev_q;
  assign mem_o   = mem_q;
  assign link_o  = link_q;
  assign bytes_o = wc_bytes(wc_q);
  assign last_o  = (cnt_q == ONE);
  assign bad_o   = (wc_bytes(wc_q) == 3'd0) || (cnt_q == '0) ||
                   ((wc_q != WC_WORD) && (cnt_q > NARROW_MAX));

  // R4
  cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q != '0));

  // R4
  dev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(dev_q));

endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       chain_i,
  input  logic       to_dev_i,
  input  logic       fetch_done_i,
  input  logic       bad_i,
  input  logic       last_i,
  input  logic [1:0] link_code_i,
  input  logic       xfer_ack_i,
  output logic [1:0] state_o,
  output logic       ld_cfg_o,
  output logic       go_fetch_o,
  output logic       step_o,
  output logic       xfer_req_o,
  output logic       to_dev_o,
  output logic       done_o,
  output logic       err_o
);

  chan_st_e st_q, st_d;
  logic     chain_q, chain_d;
  logic     dir_q, dir_d;
  logic     done_q, done_d;
  logic     err_q, err_d;

  always_comb begin
    st_d       = st_q;
    chain_d    = chain_q;
    dir_d      = dir_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    ld_cfg_o   = 1'b0;
    go_fetch_o = 1'b0;
    step_o     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ld_cfg_o = 1'b1;
          chain_d  = chain_i;
          dir_d    = to_dev_i;
          st_d     = ST_CHECK;
        end
      end
      ST_FETCH: begin
        if (fetch_done_i) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (bad_i) begin
          err_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (xfer_ack_i) begin
          step_o = 1'b1;
          if (last_i) begin
            done_d = link_code_i[0];
            if (chain_q && link_code_i[1]) begin
              go_fetch_o = 1'b1;
              st_d       = ST_FETCH;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chain_q <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (ld_cfg_o) begin
        chain_q <= chain_d;
        dir_q   <= dir_d;
      end
    end
  end

  assign state_o    = st_q;
  assign xfer_req_o = (st_q == ST_MOVE);
  assign to_dev_o   = dir_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R8
  err_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == ST_IDLE));

  // R8
  move_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MOVE) |-> !bad_i);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_i) |=> ($stable(chain_q) && $stable(dir_q)));

  // R5
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && last_i && !link_code_i[0]) |=> !done_q);

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chain_mode_i,
  input  logic          to_dev_i,
  input  logic [AW-1:0] cfg_dev_addr_i,
  input  logic [AW-1:0] cfg_mem_addr_i,
  input  logic [AW-1:0] cfg_size_i,
  input  logic [AW-1:0] cfg_next_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_data_i,
  output logic          xfer_req_o,
  output logic          xfer_to_dev_o,
  output logic [AW-1:0] xfer_dev_addr_o,
  output logic [AW-1:0] xfer_mem_addr_o,
  output logic [2:0]    xfer_bytes_o,
  input  logic          xfer_ack_i,
  output logic [1:0]    state_o,
  output logic          done_o,
  output logic          err_o
);

  logic                          ld_cfg, go_fetch, step, fetch_done;
  logic                          bad, last;
  logic [AW-1:0]                 link;
  logic [DESC_WORDS-1:0][AW-1:0] fwords;

  dmach_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .chain_i      (chain_mode_i),
    .to_dev_i     (to_dev_i),
    .fetch_done_i (fetch_done),
    .bad_i        (bad),
    .last_i       (last),
    .link_code_i  (link[1:0]),
    .xfer_ack_i   (xfer_ack_i),
    .state_o      (state_o),
    .ld_cfg_o     (ld_cfg),
    .go_fetch_o   (go_fetch),
    .step_o       (step),
    .xfer_req_o   (xfer_req_o),
    .to_dev_o     (xfer_to_dev_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  dmach_path #(.AW(AW), .CNT_W(CNT_W)) u_path (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_cfg_i      (ld_cfg),
    .cfg_dev_i     (cfg_dev_addr_i),
    .cfg_mem_i     (cfg_mem_addr_i),
    .cfg_size_i    (cfg_size_i),
    .cfg_link_i    (cfg_next_i),
    .ld_fetch_i    (fetch_done),
    .fetch_words_i (fwords),
    .step_i        (step),
    .dev_o         (xfer_dev_addr_o),
    .mem_o         (xfer_mem_addr_o),
    .link_o        (link),
    .bytes_o       (xfer_bytes_o),
    .last_o        (last),
    .bad_o         (bad)
  );

  dmach_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_fetch),
    .base_i     (link),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .words_o    (fwords),
    .done_o     (fetch_done)
  );

endmodule

// File: tb/sim_dma_chain_channel.sv
module sim_dma_chain_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, chain_mode_i, to_dev_i;
  logic [31:0] cfg_dev, cfg_mem, cfg_size, cfg_next;
  logic        rd_req_o, rd_valid_i;
  logic [31:0] rd_addr_o, rd_data_i;
  logic        xfer_req_o, xfer_to_dev_o, xfer_ack_i;
  logic [31:0] xfer_dev_addr_o, xfer_mem_addr_o;
  logic [2:0]  xfer_bytes_o;
  logic [1:0]  state_o;
  logic        done_o, err_o;

  always #2.5 clk = ~clk;

  dma_chain_channel u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_mode_i(chain_mode_i),
    .to_dev_i(to_dev_i), .cfg_dev_addr_i(cfg_dev), .cfg_mem_addr_i(cfg_mem),
    .cfg_size_i(cfg_size), .cfg_next_i(cfg_next), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .xfer_req_o(xfer_req_o), .xfer_to_dev_o(xfer_to_dev_o),
    .xfer_dev_addr_o(xfer_dev_addr_o), .xfer_mem_addr_o(xfer_mem_addr_o),
    .xfer_bytes_o(xfer_bytes_o), .xfer_ack_i(xfer_ack_i), .state_o(state_o),
    .done_o(done_o), .err_o(err_o)
  );

  int nchk = 0;
  int nfail = 0;

  // responder logs
  logic [31:0] dmem [16];
  logic [31:0] lg_mem [16];
  logic [31:0] lg_dev [16];
  logic [2:0]  lg_by [16];
  logic [31:0] lg_rd [16];
  logic [31:0] first_mem, last_mem, last_dev;
  logic [2:0]  last_by;
  int  ack_n, rd_n, done_n, err_n, both_n, dir_bad, fetch_seen;
  logic stall, exp_dir;
  logic [31:0] cyc = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    ack_n = 0; rd_n = 0; done_n = 0; err_n = 0; both_n = 0;
    dir_bad = 0; fetch_seen = 0; first_mem = '0; last_mem = '0;
    last_dev = '0; last_by = '0;
  endtask

  // memory and transfer responders, acting at the falling edge
  initial begin
    rd_valid_i = 1'b0; rd_data_i = '0; xfer_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      rd_valid_i = rd_req_o;
      rd_data_i  = dmem[rd_addr_o[5:2]];
      if (rd_req_o) begin
        if (rd_n < 16) lg_rd[rd_n] = rd_addr_o;
        rd_n++;
      end
      if (state_o == 2'd1) fetch_seen++;
      xfer_ack_i = xfer_req_o && (!stall || cyc[0]);
      if (xfer_ack_i) begin
        if (ack_n < 16) begin
          lg_mem[ack_n] = xfer_mem_addr_o;
          lg_dev[ack_n] = xfer_dev_addr_o;
          lg_by[ack_n]  = xfer_bytes_o;
        end
        if (ack_n == 0) first_mem = xfer_mem_addr_o;
        last_mem = xfer_mem_addr_o;
        last_dev = xfer_dev_addr_o;
        last_by  = xfer_bytes_o;
        if (xfer_to_dev_o !== exp_dir) dir_bad++;
        ack_n++;
      end
      if (done_o) done_n++;
      if (err_o) err_n++;
      if (done_o && err_o) both_n++;
    end
  end

  function automatic logic [31:0] size_word(input logic [1:0] wc, input logic [10:0] cnt);
    return {18'd0, wc, 1'b0, cnt};
  endfunction

  task automatic wait_idle();
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (state_o == 2'd0) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input logic chain, input logic dir);
    @(negedge clk);
    chain_mode_i = chain; to_dev_i = dir; exp_dir = dir;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // vectors: [47] dir, [46:45] width code, [44:34] count, [33:32] link code, [31:0] mem
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 2'd3, 11'd3,     2'd1, 32'h0000_0100},
    {1'b1, 2'd2, 11'd2,     2'd0, 32'h0000_0200},
    {1'b0, 2'd0, 11'd4,     2'd3, 32'h0000_0300},
    {1'b0, 2'd1, 11'd2,     2'd1, 32'h0000_0400},
    {1'b1, 2'd3, 11'd0,     2'd0, 32'h0000_0500},
    {1'b0, 2'd2, 11'h400,   2'd1, 32'h0000_0600},
    {1'b1, 2'd0, 11'h400,   2'd1, 32'h0001_0000},
    {1'b0, 2'd3, 11'h3FF,   2'd0, 32'h0002_0000}
  };

  initial begin
    rst_n = 1'b0; start_i = 1'b0; chain_mode_i = 1'b0; to_dev_i = 1'b0;
    cfg_dev = '0; cfg_mem = '0; cfg_size = '0; cfg_next = '0;
    stall = 1'b0; exp_dir = 1'b0;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 state in reset", state_o, 0);
    chk("R1 xfer_req in reset", xfer_req_o, 0);
    chk("R1 rd_req in reset", rd_req_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 state after reset", state_o, 0);
    chk("R1 no pulses after reset", {done_n, err_n}, 0);

    // table walk: one-shot runs (R3 R4 R5 R6 R8 R10)
    for (int v = 0; v < NV; v++) begin
      logic [1:0] wc; logic [10:0] cnt; logic [1:0] code; logic [31:0] m;
      logic bad; int by, ea;
      wc = VEC[v][46:45]; cnt = VEC[v][44:34]; code = VEC[v][33:32]; m = VEC[v][31:0];
      by = (wc == 2'd3) ? 1 : (wc == 2'd2) ? 2 : (wc == 2'd0) ? 4 : 0;
      bad = (by == 0) || (cnt == 0) || (wc != 2'd0 && cnt > 11'h3FF);
      ea = bad ? 0 : int'(cnt);
      clear_logs();
      cfg_dev = 32'hD000_0000 + v; cfg_mem = m; cfg_size = size_word(wc, cnt);
      cfg_next = 32'h0000_1000 | {30'd0, code};
      stall = v[0];
      launch(1'b0, VEC[v][47]);
      wait_idle();
      chk($sformatf("R4 vec%0d element count", v), ack_n, ea);
      chk($sformatf("R5 vec%0d completion pulses", v), done_n, bad ? 1 : int'(code[0]));
      chk($sformatf("R8 vec%0d error pulses", v), err_n, bad ? 1 : 0);
      chk($sformatf("R6 vec%0d no descriptor read", v), rd_n, 0);
      chk($sformatf("R10 vec%0d direction", v), dir_bad, 0);
      if (bad) begin
        chk($sformatf("R8 vec%0d error with completion", v), both_n, 1);
      end else begin
        chk($sformatf("R3 vec%0d first address", v), first_mem, m);
        chk($sformatf("R3 vec%0d last address", v), last_mem, m + (cnt - 1) * by);
        chk($sformatf("R3 vec%0d byte count", v), last_by, by);
        chk($sformatf("R4 vec%0d device fixed", v), last_dev, 32'hD000_0000 + v);
      end
      chk($sformatf("R6 vec%0d back to idle", v), state_o, 0);
    end

    // R2: state sequence after start
    clear_logs(); stall = 1'b1;
    cfg_dev = 32'hDEAD_0000; cfg_mem = 32'h0000_8000;
    cfg_size = size_word(2'd0, 11'd2); cfg_next = 32'd0;
    @(negedge clk);
    chain_mode_i = 1'b0; to_dev_i = 1'b0; exp_dir = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 check state", state_o, 2);
    @(negedge clk);
    chk("R2 access state", state_o, 3);
    chk("R2 mem address presented", xfer_mem_addr_o, 32'h0000_8000);
    chk("R2 dev address presented", xfer_dev_addr_o, 32'hDEAD_0000);
    wait_idle();
    chk("R2 elements", ack_n, 2);

    // R9: start while busy, with changed configuration
    clear_logs(); stall = 1'b1;
    cfg_mem = 32'h0000_0500; cfg_size = size_word(2'd0, 11'd4); cfg_next = 32'd1;
    launch(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    cfg_mem = 32'h0000_0900; cfg_size = size_word(2'd3, 11'd1); to_dev_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R9 busy start ignored count", ack_n, 4);
    chk("R9 busy start ignored last address", last_mem, 32'h0000_050C);
    chk("R9 busy start ignored direction", dir_bad, 0);

    // R9: start on the cycle of the final acknowledge
    clear_logs(); stall = 1'b0;
    cfg_mem = 32'h0000_0A00; cfg_size = size_word(2'd3, 11'd1); cfg_next = 32'd0;
    launch(1'b0, 1'b0);
    @(negedge clk);
    cfg_mem = 32'h0000_0777;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 collision single element", ack_n, 1);
    chk("R9 collision address", last_mem, 32'h0000_0A00);
    chk("R9 collision idle", state_o, 0);

    // R7 R10: three-descriptor chain
    dmem[0] = 32'h0000_00D4; dmem[1] = 32'h0000_3000;
    dmem[2] = size_word(2'd3, 11'd3); dmem[3] = 32'h0000_1013;
    dmem[4] = 32'h0000_00D8; dmem[5] = 32'h0000_4000;
    dmem[6] = size_word(2'd2, 11'd1); dmem[7] = 32'h0000_0001;
    clear_logs(); stall = 1'b1;
    cfg_dev = 32'h0000_00D0; cfg_mem = 32'h0000_2000;
    cfg_size = size_word(2'd0, 11'd2); cfg_next = 32'h0000_1002;
    launch(1'b1, 1'b1);
    wait_idle();
    chk("R7 total elements", ack_n, 6);
    chk("R7 descriptor reads", rd_n, 8);
    chk("R7 read address 0", lg_rd[0], 32'h1000);
    chk("R7 read address 3", lg_rd[3], 32'h100C);
    chk("R7 read address 4", lg_rd[4], 32'h1010);
    chk("R7 fetch state seen", fetch_seen > 0, 1);
    chk("R7 elem2 dev", lg_dev[2], 32'hD4);
    chk("R7 elem2 mem", lg_mem[2], 32'h3000);
    chk("R7 elem4 mem", lg_mem[4], 32'h3002);
    chk("R7 elem5 mem", lg_mem[5], 32'h4000);
    chk("R7 elem5 bytes", lg_by[5], 2);
    chk("R7 elem1 mem", lg_mem[1], 32'h2004);
    chk("R5 chain completions", done_n, 2);
    chk("R10 chain direction", dir_bad, 0);

    // R11: malformed descriptor reached through the chain
    dmem[8] = 32'h0000_00DC; dmem[9] = 32'h0000_5000;
    dmem[10] = size_word(2'd0, 11'd0); dmem[11] = 32'h0000_0001;
    clear_logs(); stall = 1'b0;
    cfg_dev = 32'h0000_00D0; cfg_mem = 32'h0000_6000;
    cfg_size = size_word(2'd2, 11'd2); cfg_next = 32'h0000_1022;
    launch(1'b1, 1'b0);
    wait_idle();
    chk("R11 elements before error", ack_n, 2);
    chk("R11 error pulse", err_n, 1);
    chk("R11 completion with error", both_n, 1);
    chk("R11 completion count", done_n, 1);
    chk("R11 idle", state_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule